// File: doc/BRIEF.md
# Ready/Busy Aggregator for a Multi-Device Flash Card

This block merges the individual ready/busy lines of up to a dozen flash devices into one card-level ready indication. Each device line is first brought into the local clock domain. The host then sees the combined result through a small register port. That port offers per-device masking, a raw status view, a summary word and a mode control.

In level mode the card output is high only while every device that is not masked reports ready. In event mode the output stays low. Each busy-to-ready transition of an unmasked device is queued, and the output rises for one queued event at a time. The host answers each report by clearing the acknowledge flag. Clearing it drops the output, and the output rises again for the next queued event. When several events are waiting, the lowest device index is served first.

Top module: `rdy_aggregator`

## Requirements
- R1: After reset the block is in level mode, both mask registers read 0x00, the mode register reads 0x00 and no events are queued.
- R2: Register index 0 holds the masks of devices 0..7 in bits 0..7. Register index 1 holds the masks of devices 8..11 in bits 0..3, and its bits 4..7 always read 0. A mask bit of 1 excludes that device.
- R3: Register index 2 (devices 0..7) and register index 3 (devices 8..11) use the same bit layout as the masks. They show each synchronized device line, where 1 means ready, within SYNC_STAGES clock cycles of a change.
- R4: In level mode (mode register bit 0 = 0), card_ready is 1 when all unmasked devices are ready and 0 when any unmasked device is busy.
- R5: A busy device whose mask bit is 1 does not pull card_ready low in level mode.
- R6: Register index 5 reads bit 0 as the OR of all mask bits and bit 1 as 1 only when every device line is ready, whether masked or not. Its other bits read 0.
- R7: In event mode (mode register index 4, bit 0 = 1), card_ready stays low while nothing is queued. A device going busy does not raise it. A busy-to-ready transition of an unmasked device raises card_ready, and the acknowledge flag (mode register bit 1) then reads 1.
- R8: Writing the mode register with bit 1 = 0 clears the acknowledge flag, and card_ready is low in the very next cycle. Another queued event then raises card_ready again, lowest device index first. Once no events remain, card_ready stays low.
- R9: In event mode, a ready transition of a masked device queues no event.
- R10: Leaving event mode discards all queued events and clears the acknowledge flag. A later return to event mode starts with card_ready low.
- R11: Writing 1 to the acknowledge bit never sets it. Only a reported event does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_ready | input | NUM_DEV | Per-device ready lines, 1 = ready, asynchronous |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| card_ready | output | 1 | Combined card ready indication |

## Verification
The assertions assume that each device line holds its level for longer than the synchronizer depth plus one cycle. Under that assumption every transition reaches the edge detector and none is merged with a neighbour. They also assume that register writes are single-cycle strobes with stable index and data. The stimulus changes device lines and write strobes only on falling clock edges. It leaves several idle cycles after every line change before it looks at a result, and it toggles device lines only in clearly separated busy and ready phases.

// File: rtl/rbagg_pkg.sv
package rbagg_pkg;
   typedef enum logic [2:0] {
      IDX_MASK_LO = 3'd0,
      IDX_MASK_HI = 3'd1,
      IDX_STAT_LO = 3'd2,
      IDX_STAT_HI = 3'd3,
      IDX_MODE    = 3'd4,
      IDX_SUMMARY = 3'd5
   } reg_idx_e;

   localparam int MODE_EVENT_BIT = 0;
   localparam int MODE_ACK_BIT   = 1;
   localparam int REG_BYTE_W     = 8;
   localparam int MAX_DEV        = 2 * REG_BYTE_W;
endpackage

// File: rtl/rbagg_sync.sv
module rbagg_sync #(
   parameter int NUM_DEV     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] raw_in,
   output logic [NUM_DEV-1:0] sync_out
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_depth
      $error("rbagg_sync: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_bypass
      assign sync_out = raw_in;
   end else begin : g_chain
      logic [NUM_DEV-1:0] stage_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign sync_out = stage_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/rbagg_events.sv
module rbagg_events #(
   parameter int NUM_DEV = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               event_mode,
   input  logic               ack_clr,
   input  logic [NUM_DEV-1:0] dev_sync,
   input  logic [NUM_DEV-1:0] dev_mask,
   output logic               ack,
   output logic [NUM_DEV-1:0] pending,
   output logic [NUM_DEV-1:0] grant
);
   localparam logic [NUM_DEV-1:0] ONE = NUM_DEV'(1);

   logic [NUM_DEV-1:0] prev_q;
   logic [NUM_DEV-1:0] pend_q;
   logic [NUM_DEV-1:0] rise;
   logic               ack_q;
   logic               may_grant;

   assign rise      = dev_sync & ~prev_q & ~dev_mask;
   assign may_grant = event_mode && !ack_q && !ack_clr;
   // lowest set bit of the pending vector wins
   assign grant     = may_grant ? (pend_q & (~pend_q + ONE)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
         ack_q  <= 1'b0;
      end else begin
         prev_q <= dev_sync;
         if (!event_mode) begin
            pend_q <= '0;
            ack_q  <= 1'b0;
         end else begin
            pend_q <= (pend_q & ~grant) | rise;
            if (ack_clr)     ack_q <= 1'b0;
            else if (|grant) ack_q <= 1'b1;
         end
      end
   end

   assign ack     = ack_q;
   assign pending = pend_q;
endmodule

// File: rtl/rbagg_regs.sv
module rbagg_regs
   import rbagg_pkg::*;
#(
   parameter int NUM_DEV = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         addr,
   input  logic [7:0]         wdata,
   input  logic [NUM_DEV-1:0] dev_sync,
   input  logic               ack,
   output logic [NUM_DEV-1:0] dev_mask,
   output logic               event_mode,
   output logic               ack_clr,
   output logic [7:0]         rdata
);
   logic [MAX_DEV-1:0] mask_pad;
   logic [MAX_DEV-1:0] stat_pad;
   logic               mode_q;
   logic               mode_we;

   for (genvar i = 0; i < MAX_DEV; i++) begin : g_bit
      if (i < NUM_DEV) begin : g_live
         localparam logic [2:0] WIDX = (i < REG_BYTE_W) ? IDX_MASK_LO : IDX_MASK_HI;
         localparam int         WBIT = i % REG_BYTE_W;
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  bit_q <= 1'b0;
            else if (we && addr == WIDX) bit_q <= wdata[WBIT];
         end
         assign dev_mask[i] = bit_q;
         assign mask_pad[i] = bit_q;
         assign stat_pad[i] = dev_sync[i];
      end else begin : g_void
         assign mask_pad[i] = 1'b0;
         assign stat_pad[i] = 1'b0;
      end
   end

   assign mode_we = we && (addr == IDX_MODE);
   assign ack_clr = mode_we && !wdata[MODE_ACK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= 1'b0;
      else if (mode_we) mode_q <= wdata[MODE_EVENT_BIT];
   end
   assign event_mode = mode_q;

   always_comb begin
      rdata = '0;
      case (addr)
         IDX_MASK_LO: rdata = mask_pad[7:0];
         IDX_MASK_HI: rdata = mask_pad[15:8];
         IDX_STAT_LO: rdata = stat_pad[7:0];
         IDX_STAT_HI: rdata = stat_pad[15:8];
         IDX_MODE:    rdata = {6'b0, ack, mode_q};
         IDX_SUMMARY: rdata = {6'b0, &dev_sync, |dev_mask};
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/rdy_aggregator.sv
module rdy_aggregator #(
   parameter int NUM_DEV     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_ready,
   input  logic               reg_we,
   input  logic [2:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               card_ready
);
   if (NUM_DEV < 1 || NUM_DEV > rbagg_pkg::MAX_DEV) begin : g_bad_count
      $error("rdy_aggregator: NUM_DEV must be 1..16");
   end

   logic [NUM_DEV-1:0] dev_sync;
   logic [NUM_DEV-1:0] mask_q;
   logic [NUM_DEV-1:0] pend_q;
   logic [NUM_DEV-1:0] grant;
   logic               mode_ev;
   logic               ack_clr;
   logic               ack_q;
   logic               level_ok;

   rbagg_sync #(.NUM_DEV(NUM_DEV), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_in(dev_ready), .sync_out(dev_sync));

   rbagg_regs #(.NUM_DEV(NUM_DEV)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .dev_sync(dev_sync), .ack(ack_q), .dev_mask(mask_q), .event_mode(mode_ev),
      .ack_clr(ack_clr), .rdata(reg_rdata));

   rbagg_events #(.NUM_DEV(NUM_DEV)) u_events (
      .clk(clk), .rst_n(rst_n), .event_mode(mode_ev), .ack_clr(ack_clr),
      .dev_sync(dev_sync), .dev_mask(mask_q), .ack(ack_q), .pending(pend_q),
      .grant(grant));

   assign level_ok   = &(dev_sync | mask_q);
   assign card_ready = mode_ev ? ack_q : level_ok;
endmodule

// File: rtl/rbagg_checker.sv
module rbagg_checker #(
   parameter int NUM_DEV = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_ev,
   input logic               ack,
   input logic               card_ready,
   input logic [NUM_DEV-1:0] mask,
   input logic [NUM_DEV-1:0] pend,
   input logic [NUM_DEV-1:0] grant
);
   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> ((grant & pend) == grant));

   assert_no_masked_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ev |=> ((pend & ~$past(pend) & $past(mask)) == '0));

   assert_level_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ev |=> (pend == '0 && !ack));

   assert_rest_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ev && !ack) |-> !card_ready);

   assert_ack_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> ($past(pend) != '0));
endmodule

bind rdy_aggregator rbagg_checker #(.NUM_DEV(NUM_DEV)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_ev(mode_ev), .ack(ack_q),
   .card_ready(card_ready), .mask(mask_q), .pend(pend_q), .grant(grant));

// File: tb/rdy_aggregator_test.sv
`timescale 1ns/100ps
module rdy_aggregator_test;
   localparam int ND = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [ND-1:0] dev_ready = '1;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          card_ready;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   typedef struct {
      int         kind;   // 0: card_ready, 1: reg_rdata
      logic [7:0] exp;
      string      req;
   } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;

   rdy_aggregator #(.NUM_DEV(ND), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .card_ready(card_ready));

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = (it.kind == 0) ? {7'b0, card_ready} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic set_dev(input logic [ND-1:0] v);
      @(negedge clk);
      dev_ready = v;
   endtask

   // driver: pushes one expected item, sampled by the monitor in this cycle
   task automatic expect_item(input int kind, input logic [2:0] a,
                              input logic [7:0] e, input string req);
      reg_addr = a;
      #0.5;
      sb_q.push_back('{kind, e, req});
      @(negedge clk);
   endtask

   task automatic chk_out(input logic e, input string req);
      expect_item(0, reg_addr, {7'b0, e}, req);
   endtask

   task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string req);
      expect_item(1, a, e, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(6);
      // R1 reset state
      chk_reg(3'd0, 8'h00, "R1 mask lo");
      chk_reg(3'd1, 8'h00, "R1 mask hi");
      chk_reg(3'd4, 8'h00, "R1 mode");
      chk_out(1'b1, "R1 level all ready");
      chk_reg(3'd5, 8'h02, "R6 all ready no mask");
      // R2 mask layout
      wr(3'd0, 8'hA5);
      wr(3'd1, 8'hFF);
      chk_reg(3'd0, 8'hA5, "R2 mask lo");
      chk_reg(3'd1, 8'h0F, "R2 mask hi upper bits zero");
      chk_reg(3'd5, 8'h03, "R6 mask or and all ready");
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      // R3 status view
      set_dev(12'h5C3);
      idle(4);
      chk_reg(3'd2, 8'hC3, "R3 status lo");
      chk_reg(3'd3, 8'h05, "R3 status hi");
      chk_out(1'b0, "R4 busy devices");
      chk_reg(3'd5, 8'h00, "R6 not all ready");
      // R4 level mode
      set_dev(12'hFFF);
      idle(4);
      chk_out(1'b1, "R4 all ready");
      set_dev(12'hBFF);
      idle(4);
      chk_out(1'b0, "R4 dev10 busy");
      // R5 masked busy ignored
      wr(3'd1, 8'h04);
      idle(2);
      chk_out(1'b1, "R5 dev10 masked");
      set_dev(12'hBF7);
      idle(4);
      chk_out(1'b0, "R4 dev3 busy unmasked");
      set_dev(12'hFFF);
      wr(3'd1, 8'h00);
      idle(4);
      // R7 event mode
      wr(3'd4, 8'h01);
      idle(4);
      chk_out(1'b0, "R7 rests low");
      chk_reg(3'd4, 8'h01, "R7 mode reads event");
      set_dev(12'hDFB);
      idle(4);
      chk_out(1'b0, "R7 busy edge no event");
      set_dev(12'hFFF);
      idle(6);
      chk_out(1'b1, "R7 ready edge reported");
      chk_reg(3'd4, 8'h03, "R7 ack set");
      // R8 acknowledge sequencing
      wr(3'd4, 8'h01);
      chk_out(1'b0, "R8 drop after clear");
      idle(4);
      chk_out(1'b1, "R8 second event");
      wr(3'd4, 8'h01);
      idle(6);
      chk_out(1'b0, "R8 queue empty");
      // R11 host cannot set ack
      wr(3'd4, 8'h03);
      idle(4);
      chk_out(1'b0, "R11 ack write one");
      chk_reg(3'd4, 8'h01, "R11 ack stays clear");
      // R9 masked device edge
      wr(3'd0, 8'h10);
      set_dev(12'hFEF);
      idle(4);
      set_dev(12'hFFF);
      idle(6);
      chk_out(1'b0, "R9 masked ready edge");
      wr(3'd0, 8'h00);
      // R10 leaving event mode discards queue
      set_dev(12'hFFC);
      idle(4);
      set_dev(12'hFFF);
      idle(6);
      chk_out(1'b1, "R10 first of two events");
      wr(3'd4, 8'h00);
      idle(3);
      chk_reg(3'd4, 8'h00, "R10 ack cleared in level mode");
      chk_out(1'b1, "R4 level after event mode");
      wr(3'd4, 8'h01);
      idle(6);
      chk_out(1'b0, "R10 queue discarded");
      idle(2);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule